// File: doc/BRIEF.md
# Audio Playback Address Sequencer

This block keeps the current frame address of a disc drive while it plays audio. A play command loads a start frame, an end frame and a repeat count. From then on every sector strobe advances the current frame by one. When the range is used up, the block either rewinds to the start frame for another pass or stops. Seek commands pause playback, move the address, or send it back to the home frame. A resume command continues a paused playback, but only while the address is still inside the range.

The sector data path is not part of the block. A read-failure input stands in for the medium. The block only produces the current address, a two-bit playback state and a four-bit drive status nibble. A host command decoder drives it. That decoder raises a one-cycle play or seek request together with a parameter type, up to two 24-bit address fields and a repeat field. Every output is registered, so a command or strobe that is present at a clock edge shows up on the outputs right after that edge.

Top module: `cdda_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cur_addr` becomes 0, `play_state` becomes 0 (no-info) and `drive_status` becomes 2 (standby). The stored start address, end address and repeat count are cleared as well.
- R2: A play request with `param_type` 1 treats `addr_a` and `addr_b` as linear 24-bit frame numbers. The start frame and `cur_addr` are set to `addr_a`, and the end frame is set to `addr_b`. The repeat count is taken from `repeat_in`. `play_state` becomes 1 (playing) and `drive_status` becomes 3 (play).
- R3: A play request with `param_type` 2 reads each address as minute in bits 23:16, second in bits 15:8 and frame in bits 7:0. Each is converted to minute*4500 + second*75 + frame.
- R4: When the converted end address of a play request is zero, the end frame is taken from `disc_last` instead.
- R5: While playing, each `sector_tick` without `read_fail` advances `cur_addr` by one. While not playing, `sector_tick` has no effect on any output.
- R6: The advanced address can reach or pass the end frame while the repeat count is zero. In that case `cur_addr` takes the advanced value, `play_state` becomes 3 (terminated) and `drive_status` becomes 1 (pause).
- R7: The advanced address can reach or pass the end frame while the repeat count is nonzero. In that case `cur_addr` reloads the start frame and playback continues. The count drops by one, except that a count of 15 never changes, so playback repeats forever.
- R8: A `sector_tick` with `read_fail` while playing moves `cur_addr` back by one. `play_state` becomes 3 and `drive_status` becomes 1.
- R9: A seek request with `param_type` 1 (linear) or 2 (minute/second/frame) loads `addr_a` into the start frame and into `cur_addr`. It changes a playing state to 2 (paused) and sets `drive_status` to 1.
- R10: A seek request with `param_type` 3 loads frame 150 into the start frame and `cur_addr`. It sets `play_state` to 0 and `drive_status` to 2.
- R11: A seek request with `param_type` 4 changes a playing state to paused and sets `drive_status` to 1. The address is left unchanged.
- R12: A play request with `param_type` 7 acts only on a paused playback. If `cur_addr` does not exceed the end frame, the state becomes playing with `drive_status` 3. Otherwise the state becomes terminated with `drive_status` 2. In any other state the request changes nothing.
- R13: A play request takes priority over a seek request, and any command takes priority over a sector strobe in the same cycle. A play request of a type other than 1, 2 or 7, or a seek request of a type other than 1 to 4, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| play_req | input | 1 | One-cycle play command strobe |
| seek_req | input | 1 | One-cycle seek command strobe |
| param_type | input | 3 | Command parameter type |
| addr_a | input | 24 | Start or target address field |
| addr_b | input | 24 | End address field (play only) |
| repeat_in | input | 4 | Repeat count of a play command |
| disc_last | input | 24 | Last frame on the disc |
| sector_tick | input | 1 | One pulse per sector time |
| read_fail | input | 1 | The sector read at this strobe failed |
| cur_addr | output | 24 | Current frame address |
| play_state | output | 2 | 0 no-info, 1 playing, 2 paused, 3 terminated |
| drive_status | output | 4 | 1 pause, 2 standby, 3 play |

## Verification
The bench targets the end-of-range step. A design that compares before incrementing, or that writes a strict greater-than, would play one frame too many or stop one frame early. A design that decrements a count of 15 would stop a looping track after fifteen passes. A design that keeps the address on a failed read would report a frame that was never delivered. A resume that skips the range test would restart playback beyond the end frame. Strobes that arrive while not playing, or in the same cycle as a command, are checked so that a design that lets them move the address gets caught.

// File: rtl/cas_pkg.sv
// Shared types for the audio playback address sequencer.
// Assumes 24-bit frame addresses unless a user overrides the module parameters.
package cas_pkg;

    // Playback state as seen on the play_state output.
    typedef enum logic [1:0] {
        PS_NOINFO     = 2'd0,
        PS_PLAYING    = 2'd1,
        PS_PAUSED     = 2'd2,
        PS_TERMINATED = 2'd3
    } play_state_e;

    // Drive status nibble values.
    localparam logic [3:0] DRV_PAUSE   = 4'h1;
    localparam logic [3:0] DRV_STANDBY = 4'h2;
    localparam logic [3:0] DRV_PLAY    = 4'h3;

    // Command parameter type codes.
    localparam logic [2:0] PT_LINEAR = 3'd1;
    localparam logic [2:0] PT_MSF    = 3'd2;
    localparam logic [2:0] PT_HOME   = 3'd3;
    localparam logic [2:0] PT_PAUSE  = 3'd4;
    localparam logic [2:0] PT_RESUME = 3'd7;

endpackage

// File: rtl/cas_addr_decode.sv
// Converts one command address field to a linear frame number.
// Linear mode passes the field through. Time mode splits it into three
// equal fields (minute, second, frame, from the top down) and weights them.
// Assumes ADDR_W is a multiple of three. Purely combinational.
module cas_addr_decode #(
    parameter int ADDR_W         = 24,
    parameter int SEC_PER_MIN    = 60,
    parameter int FRAMES_PER_SEC = 75
) (
    input  logic [ADDR_W-1:0] raw,
    input  logic              time_mode,
    output logic [ADDR_W-1:0] frame
);
    localparam int FIELD_W = ADDR_W / 3;
    localparam logic [ADDR_W-1:0] W_MIN = ADDR_W'(SEC_PER_MIN * FRAMES_PER_SEC);
    localparam logic [ADDR_W-1:0] W_SEC = ADDR_W'(FRAMES_PER_SEC);

    logic [ADDR_W-1:0] mins, secs, frms;

    // Split the raw field into zero-extended minute, second and frame parts.
    always_comb begin
        mins = '0;
        secs = '0;
        frms = '0;
        mins[FIELD_W-1:0] = raw[3*FIELD_W-1:2*FIELD_W];
        secs[FIELD_W-1:0] = raw[2*FIELD_W-1:FIELD_W];
        frms[FIELD_W-1:0] = raw[FIELD_W-1:0];
    end

    // Select between the linear value and the weighted time sum.
    always_comb begin
        if (time_mode)
            frame = mins * W_MIN + secs * W_SEC + frms;
        else
            frame = raw;
    end
endmodule

// File: rtl/cas_frame_stepper.sv
// Works out the result of one sector strobe during playback: the next
// address, the next repeat count and whether playback ends. A failed read
// steps back one frame. A step that reaches the end frame either rewinds
// or terminates. The all-ones repeat code loops forever.
// Combinational; the caller applies the result only while playing.
module cas_frame_stepper #(
    parameter int ADDR_W = 24,
    parameter int REP_W  = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] start_fr,
    input  logic [ADDR_W-1:0] end_fr,
    input  logic [REP_W-1:0]  rep,
    input  logic              fail,
    output logic [ADDR_W-1:0] next_cur,
    output logic [REP_W-1:0]  next_rep,
    output logic              stop
);
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
    localparam logic [REP_W-1:0]  FOREVER = '1;
    localparam logic [REP_W-1:0]  REP_ONE = REP_W'(1);

    logic [ADDR_W-1:0] adv;
    logic              at_end;

    // Candidate forward address and end-of-range test.
    always_comb begin
        adv    = cur + ONE;
        at_end = (adv >= end_fr);
    end

    // Pick backstep, stop, rewind or plain advance.
    always_comb begin
        next_rep = rep;
        stop     = 1'b0;
        if (fail) begin
            next_cur = cur - ONE;
            stop     = 1'b1;
        end else if (at_end && rep == '0) begin
            next_cur = adv;
            stop     = 1'b1;
        end else if (at_end) begin
            next_cur = start_fr;
            if (rep != FOREVER)
                next_rep = rep - REP_ONE;
        end else begin
            next_cur = adv;
        end
    end
endmodule

// File: rtl/cas_seq_core.sv
// State holder of the sequencer: current, start and end frames, the repeat
// count, the playback state and the drive status. It applies commands
// (play before seek), then the sector strobe when no command is present.
// Assumes decoded addresses arrive already converted for the command type.
module cas_seq_core
    import cas_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int REP_W     = 4,
    parameter int HOME_ADDR = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_req,
    input  logic              seek_req,
    input  logic [2:0]        param_type,
    input  logic [ADDR_W-1:0] dec_a,
    input  logic [ADDR_W-1:0] dec_b,
    input  logic [REP_W-1:0]  repeat_in,
    input  logic [ADDR_W-1:0] disc_last,
    input  logic              sector_tick,
    input  logic              read_fail,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        play_state,
    output logic [3:0]        drive_status
);
    localparam logic [ADDR_W-1:0] HOME    = ADDR_W'(HOME_ADDR);
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
    localparam logic [REP_W-1:0]  FOREVER = '1;

    logic [ADDR_W-1:0] cur_q, start_q, end_q;
    logic [REP_W-1:0]  rep_q;
    play_state_e       state_q;
    logic [3:0]        drive_q;

    logic [ADDR_W-1:0] end_sel;
    logic [ADDR_W-1:0] step_cur;
    logic [REP_W-1:0]  step_rep;
    logic              step_stop;

    // A zero end field means the range runs to the last frame on the disc.
    always_comb end_sel = (dec_b == '0) ? disc_last : dec_b;

    cas_frame_stepper #(.ADDR_W(ADDR_W), .REP_W(REP_W)) u_step (
        .cur      (cur_q),
        .start_fr (start_q),
        .end_fr   (end_q),
        .rep      (rep_q),
        .fail     (read_fail),
        .next_cur (step_cur),
        .next_rep (step_rep),
        .stop     (step_stop)
    );

    // Command and strobe sequencing with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
            rep_q   <= '0;
            state_q <= PS_NOINFO;
            drive_q <= DRV_STANDBY;
        end else if (play_req) begin
            case (param_type)
                PT_LINEAR, PT_MSF: begin
                    start_q <= dec_a;
                    cur_q   <= dec_a;
                    end_q   <= end_sel;
                    rep_q   <= repeat_in;
                    state_q <= PS_PLAYING;
                    drive_q <= DRV_PLAY;
                end
                PT_RESUME: begin
                    if (state_q == PS_PAUSED) begin
                        if (cur_q > end_q) begin
                            state_q <= PS_TERMINATED;
                            drive_q <= DRV_STANDBY;
                        end else begin
                            state_q <= PS_PLAYING;
                            drive_q <= DRV_PLAY;
                        end
                    end
                end
                default: ;
            endcase
        end else if (seek_req) begin
            case (param_type)
                PT_LINEAR, PT_MSF: begin
                    start_q <= dec_a;
                    cur_q   <= dec_a;
                    drive_q <= DRV_PAUSE;
                    if (state_q == PS_PLAYING)
                        state_q <= PS_PAUSED;
                end
                PT_HOME: begin
                    start_q <= HOME;
                    cur_q   <= HOME;
                    state_q <= PS_NOINFO;
                    drive_q <= DRV_STANDBY;
                end
                PT_PAUSE: begin
                    drive_q <= DRV_PAUSE;
                    if (state_q == PS_PLAYING)
                        state_q <= PS_PAUSED;
                end
                default: ;
            endcase
        end else if (sector_tick && state_q == PS_PLAYING) begin
            cur_q <= step_cur;
            rep_q <= step_rep;
            if (step_stop) begin
                state_q <= PS_TERMINATED;
                drive_q <= DRV_PAUSE;
            end
        end
    end

    assign cur_addr     = cur_q;
    assign play_state   = state_q;
    assign drive_status = drive_q;

    // R5: a plain strobe inside the range advances by one.
    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PLAYING && sector_tick && !read_fail && !play_req &&
         !seek_req && (cur_q + ONE) < end_q)
        |=> (cur_q == $past(cur_q) + ONE && state_q == PS_PLAYING));

    // R5: strobes outside playback leave the address alone.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_PLAYING && sector_tick && !play_req && !seek_req)
        |=> $stable(cur_q));

    // R8: a failed read backs up one frame and terminates.
    a_r8_backstep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PLAYING && sector_tick && read_fail && !play_req && !seek_req)
        |=> (cur_q == $past(cur_q) - ONE && state_q == PS_TERMINATED));

    // R7: the loop-forever code survives every strobe.
    a_r7_forever: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PLAYING && rep_q == FOREVER && !play_req)
        |=> (rep_q == FOREVER));

    // R10: the home seek lands on the home frame with no info.
    a_r10_home: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_req && !play_req && param_type == PT_HOME)
        |=> (cur_q == HOME && state_q == PS_NOINFO));

    // R12: the drive reports play exactly while the sequencer is playing.
    a_r12_drive_match: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PS_PLAYING) == (drive_q == DRV_PLAY)));
endmodule

// File: rtl/cdda_addr_seq.sv
// Top of the audio playback address sequencer. It decodes the two command
// address fields (linear or minute/second/frame) and feeds them to the
// sequencing core. Assumes play_req and seek_req are one-cycle strobes.
module cdda_addr_seq
    import cas_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int REP_W          = 4,
    parameter int HOME_ADDR      = 150,
    parameter int SEC_PER_MIN    = 60,
    parameter int FRAMES_PER_SEC = 75
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_req,
    input  logic              seek_req,
    input  logic [2:0]        param_type,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [REP_W-1:0]  repeat_in,
    input  logic [ADDR_W-1:0] disc_last,
    input  logic              sector_tick,
    input  logic              read_fail,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        play_state,
    output logic [3:0]        drive_status
);
    localparam int N_FIELDS = 2;

    logic [ADDR_W-1:0] raw_f [N_FIELDS];
    logic [ADDR_W-1:0] dec_f [N_FIELDS];
    logic              time_mode;

    // Time-code conversion applies only to the minute/second/frame type.
    always_comb time_mode = (param_type == PT_MSF);

    assign raw_f[0] = addr_a;
    assign raw_f[1] = addr_b;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_dec
        cas_addr_decode #(
            .ADDR_W         (ADDR_W),
            .SEC_PER_MIN    (SEC_PER_MIN),
            .FRAMES_PER_SEC (FRAMES_PER_SEC)
        ) u_dec (
            .raw       (raw_f[i]),
            .time_mode (time_mode),
            .frame     (dec_f[i])
        );
    end

    cas_seq_core #(
        .ADDR_W    (ADDR_W),
        .REP_W     (REP_W),
        .HOME_ADDR (HOME_ADDR)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .play_req     (play_req),
        .seek_req     (seek_req),
        .param_type   (param_type),
        .dec_a        (dec_f[0]),
        .dec_b        (dec_f[1]),
        .repeat_in    (repeat_in),
        .disc_last    (disc_last),
        .sector_tick  (sector_tick),
        .read_fail    (read_fail),
        .cur_addr     (cur_addr),
        .play_state   (play_state),
        .drive_status (drive_status)
    );
endmodule

// File: tb/tb_cdda_addr_seq.sv
// Directed bench for the audio playback address sequencer.
module tb_cdda_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        play_req = 1'b0, seek_req = 1'b0;
    logic [2:0]  param_type = '0;
    logic [23:0] addr_a = '0, addr_b = '0;
    logic [3:0]  repeat_in = '0;
    logic [23:0] disc_last = 24'd5000;
    logic        sector_tick = 1'b0, read_fail = 1'b0;
    logic [23:0] cur_addr;
    logic [1:0]  play_state;
    logic [3:0]  drive_status;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cdda_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .play_req(play_req), .seek_req(seek_req),
        .param_type(param_type), .addr_a(addr_a), .addr_b(addr_b),
        .repeat_in(repeat_in), .disc_last(disc_last), .sector_tick(sector_tick),
        .read_fail(read_fail), .cur_addr(cur_addr), .play_state(play_state),
        .drive_status(drive_status)
    );

    task automatic expect_out(input string tag, input logic [23:0] ec,
                              input logic [1:0] es, input logic [3:0] ed);
        checks++;
        if (cur_addr !== ec || play_state !== es || drive_status !== ed) begin
            failures++;
            $display("FAIL %s: addr/state/drive got %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, cur_addr, play_state, drive_status, ec, es, ed);
        end
    endtask

    // Drives one cycle of stimulus from a falling edge to the next one.
    task automatic cycle(input logic pl, input logic sk, input logic [2:0] pt,
                         input logic [23:0] a, input logic [23:0] b,
                         input logic [3:0] rp, input logic tk, input logic fl);
        play_req = pl; seek_req = sk; param_type = pt; addr_a = a; addr_b = b;
        repeat_in = rp; sector_tick = tk; read_fail = fl;
        @(negedge clk);
        play_req = 1'b0; seek_req = 1'b0; sector_tick = 1'b0; read_fail = 1'b0;
    endtask

    task automatic play(input logic [2:0] pt, input logic [23:0] a,
                        input logic [23:0] b, input logic [3:0] rp);
        cycle(1'b1, 1'b0, pt, a, b, rp, 1'b0, 1'b0);
    endtask
    task automatic seek(input logic [2:0] pt, input logic [23:0] a);
        cycle(1'b0, 1'b1, pt, a, '0, '0, 1'b0, 1'b0);
    endtask
    task automatic tick(input logic fl);
        cycle(1'b0, 1'b0, 3'd0, '0, '0, '0, 1'b1, fl);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 reset", 24'd0, 2'd0, 4'd2);
    endtask

    task automatic t_linear_stop();
        play(3'd1, 24'd100, 24'd103, 4'd0);
        expect_out("R2 linear load", 24'd100, 2'd1, 4'd3);
        tick(1'b0); expect_out("R5 step", 24'd101, 2'd1, 4'd3);
        tick(1'b0); expect_out("R5 step", 24'd102, 2'd1, 4'd3);
        tick(1'b0); expect_out("R6 end stop", 24'd103, 2'd3, 4'd1);
        tick(1'b0); expect_out("R5 strobe ignored when stopped", 24'd103, 2'd3, 4'd1);
    endtask

    task automatic t_repeat();
        play(3'd1, 24'd200, 24'd202, 4'd2);
        tick(1'b0); expect_out("R7 pass1", 24'd201, 2'd1, 4'd3);
        tick(1'b0); expect_out("R7 rewind1", 24'd200, 2'd1, 4'd3);
        tick(1'b0); tick(1'b0); expect_out("R7 rewind2", 24'd200, 2'd1, 4'd3);
        tick(1'b0); tick(1'b0); expect_out("R7 count spent", 24'd202, 2'd3, 4'd1);
    endtask

    task automatic t_forever();
        play(3'd1, 24'd10, 24'd11, 4'd15);
        for (int i = 0; i < 20; i++) tick(1'b0);
        expect_out("R7 loop forever", 24'd10, 2'd1, 4'd3);
    endtask

    task automatic t_msf_last();
        play(3'd2, {8'd1, 8'd2, 8'd3}, {8'd1, 8'd2, 8'd5}, 4'd0);
        expect_out("R3 time code start", 24'd4653, 2'd1, 4'd3);
        tick(1'b0); tick(1'b0);
        expect_out("R3 time code end", 24'd4655, 2'd3, 4'd1);
        play(3'd1, 24'd4998, 24'd0, 4'd0);
        tick(1'b0); tick(1'b0);
        expect_out("R4 disc end used", 24'd5000, 2'd3, 4'd1);
    endtask

    task automatic t_fail();
        play(3'd1, 24'd300, 24'd400, 4'd0);
        tick(1'b0);
        tick(1'b1); expect_out("R8 read failure", 24'd300, 2'd3, 4'd1);
    endtask

    task automatic t_seek_resume();
        play(3'd1, 24'd500, 24'd600, 4'd0);
        tick(1'b0);
        seek(3'd1, 24'd550); expect_out("R9 seek pauses", 24'd550, 2'd2, 4'd1);
        tick(1'b0); expect_out("R5 strobe ignored when paused", 24'd550, 2'd2, 4'd1);
        play(3'd7, '0, '0, '0); expect_out("R12 resume", 24'd550, 2'd1, 4'd3);
        tick(1'b0); expect_out("R12 resumed step", 24'd551, 2'd1, 4'd3);
        seek(3'd2, {8'd0, 8'd1, 8'd0}); expect_out("R9 time code seek", 24'd75, 2'd2, 4'd1);
        play(3'd7, '0, '0, '0);
        seek(3'd4, '0); expect_out("R11 pause only", 24'd75, 2'd2, 4'd1);
        seek(3'd1, 24'd700);
        play(3'd7, '0, '0, '0); expect_out("R12 resume beyond end", 24'd700, 2'd3, 4'd2);
        play(3'd7, '0, '0, '0); expect_out("R12 resume not paused", 24'd700, 2'd3, 4'd2);
    endtask

    task automatic t_home();
        play(3'd1, 24'd20, 24'd30, 4'd0);
        tick(1'b0);
        seek(3'd3, 24'd999); expect_out("R10 home", 24'd150, 2'd0, 4'd2);
        tick(1'b0); expect_out("R10 home no play", 24'd150, 2'd0, 4'd2);
    endtask

    task automatic t_priority();
        cycle(1'b1, 1'b0, 3'd1, 24'd40, 24'd50, 4'd0, 1'b1, 1'b0);
        expect_out("R13 play over strobe", 24'd40, 2'd1, 4'd3);
        cycle(1'b1, 1'b1, 3'd1, 24'd60, 24'd70, 4'd0, 1'b0, 1'b0);
        expect_out("R13 play over seek", 24'd60, 2'd1, 4'd3);
        play(3'd3, 24'd999, 24'd1000, 4'd0);
        expect_out("R13 unknown play type", 24'd60, 2'd1, 4'd3);
        seek(3'd5, 24'd999);
        expect_out("R13 unknown seek type", 24'd60, 2'd1, 4'd3);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_linear_stop();
        t_repeat();
        t_forever();
        t_msf_last();
        t_fail();
        t_seek_resume();
        t_home();
        t_priority();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule